// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block sits beside a DRAM access controller. It decides when the memory is usable and when refresh cycles must be inserted. After reset it keeps the controller idle for a start-up pause of a programmable number of clock cycles. It then asks for a short burst of refresh cycles. Only when the controller has acknowledged the whole burst does it raise its ready flag.

In normal operation an interval timer marks each refresh slot. The slot length is a parameter in clock cycles. The default is about 15.6 µs at 100 MHz, which spreads 4096 rows over 64 ms. Each slot adds one owed refresh to a small counter, which saturates. The request line stays high while anything is owed, so slots the controller could not serve in time are caught up back to back. One request/acknowledge handshake covers both the initial burst and the periodic work.

A 12-bit row index advances on every accepted refresh and wraps. A controller using RAS-only refresh takes its row address from this index. A controller using CAS-before-RAS refresh can ignore it.

Top module: `rfsh_sched`

## Requirements
- R1: After `rst_n` is released, a two-stage synchronizer delays the internal reset. `rfsh_req` is then first seen high right after the clock edge that follows the release by PAUSE_CYC+2 edges, and `mem_ready` stays low throughout.
- R2: After the pause, `rfsh_req` stays high until INIT_REFRESHES (default 8) handshakes have been accepted, and `mem_ready` stays low during that burst.
- R3: `mem_ready` goes high right after the edge that accepts the last burst handshake, and it stays high until the next reset.
- R4: Once ready, one refresh becomes owed every INTERVAL_CYC clock edges, counted from the edge that accepted the last burst handshake. `rfsh_req` is high exactly while the owed count is non-zero.
- R5: The owed count saturates at MAX_PENDING (default 8). Each accepted handshake lowers it by one. A slot and an accepted handshake on the same edge leave it unchanged.
- R6: A handshake is accepted only on an edge where `rfsh_req` and `rfsh_ack` are both high. `rfsh_ack` while `rfsh_req` is low changes neither `rfsh_row` nor the owed count; this includes the whole start-up pause.
- R7: `rfsh_row` is ROW_BITS (default 12) wide and starts at 0. It advances by one on each accepted handshake, burst included, and wraps from 4095 to 0.
- R8: Driving `rst_n` low forces `rfsh_req` and `mem_ready` low and `rfsh_row` to 0 without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rfsh_ack | input | 1 | Controller has performed the requested refresh |
| rfsh_req | output | 1 | A refresh cycle is wanted |
| mem_ready | output | 1 | Start-up pause and initial burst are complete |
| rfsh_row | output | ROW_BITS | Row to refresh for RAS-only refresh |

## Verification
The owed-refresh logic is tried with several patterns:
- a single slot served at once, which separates correct slot timing from an off-by-one interval;
- three slots left to pile up and then drained, which shows whether owed work is counted or merely flagged;
- ten slots left unserved and then drained, which checks saturation at eight against a wrapping or unbounded count;
- a slot that lands on the same edge as an acknowledge, which exposes any wrong priority between increment and decrement.

Acknowledges given while no request is up, during the pause and after a drain, are checked against the row output. Counting edges to the first request and across the burst pins down the pause length and the burst size. A long run of refreshes walks the row index through its wrap.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  // Phases of the scheduler, in the order they are visited after reset
  typedef enum logic [1:0] {
    PH_PAUSE = 2'd0,
    PH_BURST = 2'd1,
    PH_RUN   = 2'd2
  } phase_e;
endpackage

// File: rtl/rfsh_rst_sync.sv
module rfsh_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
  parameter int LIMIT = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign tick    = en && at_last;

  // Cleared whenever disabled, so each enable starts a full period
  always_comb begin
    if (!en)          cnt_d = '0;
    else if (at_last) cnt_d = '0;
    else              cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/rfsh_owed.sv
module rfsh_owed #(
  parameter int MAX_PENDING    = 8,
  parameter int INIT_REFRESHES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic slot,
  input  logic take,
  output logic nonzero,
  output logic last_one
);
  localparam int CW = $clog2(MAX_PENDING + 1);
  localparam logic [CW-1:0] CAP  = CW'(MAX_PENDING);
  localparam logic [CW-1:0] INIT = CW'(INIT_REFRESHES);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          inc;
  logic          dec;

  assign dec = take && (cnt_q != '0);
  // At the cap a new slot only counts if a handshake frees room
  assign inc = slot && ((cnt_q != CAP) || dec);

  always_comb begin
    cnt_d = cnt_q;
    if (load)            cnt_d = INIT;
    else if (inc && !dec) cnt_d = cnt_q + CW'(1);
    else if (dec && !inc) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign nonzero  = (cnt_q != '0);
  assign last_one = (cnt_q == CW'(1));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CAP);
  assert_drain_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !slot && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/rfsh_rowctr.sv
module rfsh_rowctr #(
  parameter int ROW_BITS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  output logic [ROW_BITS-1:0] row
);
  logic [ROW_BITS-1:0] row_q;
  logic [ROW_BITS-1:0] row_d;

  // Natural binary wrap gives modulo 2**ROW_BITS
  always_comb begin
    row_d = row_q;
    if (adv) row_d = row_q + ROW_BITS'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_q <= '0;
    else        row_q <= row_d;
  end

  assign row = row_q;
endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched #(
  parameter int PAUSE_CYC      = 20000,
  parameter int INTERVAL_CYC   = 1560,
  parameter int INIT_REFRESHES = 8,
  parameter int MAX_PENDING    = 8,
  parameter int ROW_BITS       = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rfsh_ack,
  output logic                rfsh_req,
  output logic                mem_ready,
  output logic [ROW_BITS-1:0] rfsh_row
);
  import rfsh_pkg::*;

  logic   rst_i;
  phase_e phase_q;
  phase_e phase_d;
  logic   pause_tick;
  logic   slot_tick;
  logic   owed_nz;
  logic   owed_last;
  logic   take;

  rfsh_rst_sync u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i)
  );

  rfsh_timer #(.LIMIT(PAUSE_CYC)) u_pause (
    .clk   (clk),
    .rst_n (rst_i),
    .en    (phase_q == PH_PAUSE),
    .tick  (pause_tick)
  );

  rfsh_timer #(.LIMIT(INTERVAL_CYC)) u_slot (
    .clk   (clk),
    .rst_n (rst_i),
    .en    (phase_q == PH_RUN),
    .tick  (slot_tick)
  );

  // The burst reuses the owed counter: it is preloaded when the pause ends
  rfsh_owed #(.MAX_PENDING(MAX_PENDING), .INIT_REFRESHES(INIT_REFRESHES)) u_owed (
    .clk      (clk),
    .rst_n    (rst_i),
    .load     (pause_tick),
    .slot     (slot_tick),
    .take     (take),
    .nonzero  (owed_nz),
    .last_one (owed_last)
  );

  rfsh_rowctr #(.ROW_BITS(ROW_BITS)) u_row (
    .clk   (clk),
    .rst_n (rst_i),
    .adv   (take),
    .row   (rfsh_row)
  );

  assign rfsh_req  = (phase_q != PH_PAUSE) && owed_nz;
  assign take      = rfsh_req && rfsh_ack;
  assign mem_ready = (phase_q == PH_RUN);

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_PAUSE: if (pause_tick)          phase_d = PH_BURST;
      PH_BURST: if (take && owed_last)   phase_d = PH_RUN;
      PH_RUN:                            phase_d = PH_RUN;
      default:                           phase_d = PH_PAUSE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) phase_q <= PH_PAUSE;
    else        phase_q <= phase_d;
  end

  assert_row_step_R7: assert property (@(posedge clk) disable iff (!rst_i)
    (rfsh_req && rfsh_ack) |=> (rfsh_row == ROW_BITS'($past(rfsh_row) + 1'b1)));
  assert_row_hold_R6: assert property (@(posedge clk) disable iff (!rst_i)
    !(rfsh_req && rfsh_ack) |=> $stable(rfsh_row));
  assert_ready_sticky_R3: assert property (@(posedge clk) disable iff (!rst_i)
    mem_ready |=> mem_ready);
  assert_ready_cause_R3: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(mem_ready) |-> $past(rfsh_req && rfsh_ack));
  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_i)
    (rfsh_req && !rfsh_ack) |=> rfsh_req);
  assert_pause_quiet_R1: assert property (@(posedge clk) disable iff (!rst_i)
    !mem_ready && !rfsh_req |=> !mem_ready);
endmodule

// File: tb/rfsh_sched_tb.sv
`timescale 1ns/1ps
module rfsh_sched_tb;
  localparam int P  = 40;
  localparam int IV = 20;

  logic        clk;
  logic        rst_n;
  logic        ack;
  logic        req;
  logic        rdy;
  logic [11:0] row;

  int  nchk;
  int  nfail;
  bit  done;

  rfsh_sched #(.PAUSE_CYC(P), .INTERVAL_CYC(IV), .INIT_REFRESHES(8),
               .MAX_PENDING(8), .ROW_BITS(12)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .rfsh_ack  (ack),
    .rfsh_req  (req),
    .mem_ready (rdy),
    .rfsh_row  (row)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {idle edges, ack edges, expected req, expected row}, counted from burst end
  localparam int NV = 13;
  localparam int VEC [NV][4] = '{
    '{19, 0, 0,  8},  // R4 no slot yet
    '{ 1, 0, 1,  8},  // R4 first slot at edge 20
    '{ 0, 1, 0,  9},  // R5 drained
    '{ 0, 2, 0,  9},  // R6 acks ignored while idle
    '{57, 0, 1,  9},  // R4 three slots owed
    '{ 0, 2, 1, 11},  // R5 one left
    '{ 0, 1, 0, 12},  // R5 drained
    '{197, 0, 1, 12}, // R5 ten slots, capped at eight
    '{ 0, 7, 1, 19},  // R5 one left after cap
    '{ 0, 1, 0, 20},  // R5 drained
    '{12, 0, 1, 20},  // R4 slot at edge 300
    '{19, 1, 1, 21},  // R5 slot and ack on the same edge
    '{ 0, 1, 0, 22}   // R5 drained
  };

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called at a negedge, returns at the next negedge
  task automatic step(input bit a);
    ack = a;
    @(posedge clk);
    @(negedge clk);
    ack = 1'b0;
  endtask

  initial begin
    nchk = 0; nfail = 0; done = 1'b0;
    rst_n = 1'b0; ack = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 reset req", int'(req), 0);
    chk("R8 reset ready", int'(rdy), 0);
    chk("R8 reset row", int'(row), 0);

    // Pause: acks during the first P edges must be ignored
    rst_n = 1'b1;
    begin
      int k;
      k = 0;
      while (!req && k < 1000) begin
        step(k < P);
        k++;
      end
      chk("R1 edges to first request", k, P + 2);
    end
    chk("R6 row untouched by pause acks", int'(row), 0);
    chk("R1 ready low after pause", int'(rdy), 0);

    // Initial burst
    for (int i = 0; i < 8; i++) begin
      step(1'b1);
      if (i == 6) begin
        chk("R2 req held before last burst ack", int'(req), 1);
        chk("R2 ready low during burst", int'(rdy), 0);
      end
    end
    chk("R3 ready after burst", int'(rdy), 1);
    chk("R2 req low after burst", int'(req), 0);
    chk("R7 row after burst", int'(row), 8);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      for (int d = 0; d < VEC[v][0]; d++) step(1'b0);
      for (int a = 0; a < VEC[v][1]; a++) step(1'b1);
      chk($sformatf("R4/R5 vector %0d req", v), int'(req), VEC[v][2]);
      chk($sformatf("R7 vector %0d row", v), int'(row), VEC[v][3]);
    end

    // Row wrap: serve every request until the index reaches its top value
    begin
      int guard;
      guard = 0;
      while (row != 12'hFFF && guard < 150000) begin
        step(req);
        guard++;
      end
      chk("R7 row reaches top", int'(row), 4095);
      guard = 0;
      while (!req && guard < 100) begin
        step(1'b0);
        guard++;
      end
      step(1'b1);
      chk("R7 row wraps to zero", int'(row), 0);
    end
    chk("R3 ready still high", int'(rdy), 1);

    // Asynchronous reset in the middle of operation
    rst_n = 1'b0;
    #1;
    chk("R8 async req", int'(req), 0);
    chk("R8 async ready", int'(rdy), 0);
    chk("R8 async row", int'(row), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule